// File: doc/BRIEF.md
# Dual-Port Pixel Output Demultiplexer

This block sits behind a pixel sampler. It takes one RGB pixel per clock, with 8 bits per colour, and steers each pixel to one of two output ports, A or B, for each colour. In single-port mode every pixel lands on port A and port B is switched off. In dual-port mode successive pixels of a line alternate between the ports. They leave either interleaved, with one port refreshed per pixel, or as a parallel pair in which both ports refresh together once every second pixel. A control input swaps which port takes the first pixel of a line.

The input is a valid-qualified stream with no ready signal. A sampling source cannot stall, so the block always accepts a beat and applies no back-pressure. A cycle with `in_valid` low is an idle cycle. `in_hsync` is a marker on the first valid pixel of a line. All configuration inputs are captured only on that marked beat, so a mode change never splits a line or a pixel pair.

Alongside the data the block produces per-port update strobes, a data clock enable and a port-B output enable. It also produces a sync output whose width and polarity are programmable. Every output has the same fixed pipeline delay.

Top module: `pdm_pixel_demux`

## Requirements
- R1: After reset every data output is 0, `out_a_upd`, `out_b_upd`, `out_dclk_en` and `out_b_oe` are 0, and `out_hsync` is 0. The active configuration is single-port with an active-high sync of width 0.
- R2: In single-port mode (`cfg_dual`=0), each valid pixel appears on port A with `out_a_upd`=1 and `out_dclk_en`=1. Port B is not refreshed.
- R3: In dual interleaved mode (`cfg_dual`=1, `cfg_parallel`=0), pixels alternate between the ports, and each pixel refreshes only its own port. `out_dclk_en` pulses only with the second pixel of each pair, which gives half the pixel rate.
- R4: In dual parallel mode (`cfg_dual`=1, `cfg_parallel`=1), the first pixel of a pair is held. When the second pixel emerges, both ports refresh in the same cycle together with `out_dclk_en`. The first pixel alone produces no strobe.
- R5: The pixel marked with `in_hsync` is always the first of a pair, whatever pixel count came before it.
- R6: With `cfg_swap`=0 the first pixel of a pair goes to port A and the second to port B. With `cfg_swap`=1 the two are exchanged.
- R7: The values of `cfg_dual`, `cfg_parallel`, `cfg_swap`, `cfg_sync_pol` and `cfg_sync_width` take effect only on a beat with both `in_valid` and `in_hsync` high. They are ignored on every other cycle.
- R8: An idle cycle (`in_valid`=0) refreshes no port and raises no strobe. `in_hsync` during an idle cycle has no effect on alternation, configuration or sync output.
- R9: A pixel driven before clock edge k appears on the outputs after edge k+1. This delay is the same for data, strobes, `out_b_oe` and `out_hsync`.
- R10: The sync output is active for exactly `cfg_sync_width` clocks, starting together with the marked pixel's output. A width of 0 gives no pulse. `cfg_sync_pol`=1 makes the active level 1, and 0 makes the active level 0.
- R11: In parallel mode, a first pixel left unpaired when the next line starts is dropped and never reaches an output.
- R12: `out_b_oe` equals the active dual-port setting. While it is 0, the port-B data outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel present this cycle |
| in_hsync | input | 1 | Marks first pixel of a line (qualified by in_valid) |
| in_r | input | 8 | Red sample |
| in_g | input | 8 | Green sample |
| in_b | input | 8 | Blue sample |
| cfg_dual | input | 1 | 1 = dual-port mode |
| cfg_parallel | input | 1 | 1 = parallel pairs in dual mode |
| cfg_swap | input | 1 | 1 = first pixel of a pair to port B |
| cfg_sync_pol | input | 1 | 1 = active-high sync output |
| cfg_sync_width | input | 8 | Sync output width in clocks |
| out_a_r | output | 8 | Port A red |
| out_a_g | output | 8 | Port A green |
| out_a_b | output | 8 | Port A blue |
| out_b_r | output | 8 | Port B red |
| out_b_g | output | 8 | Port B green |
| out_b_b | output | 8 | Port B blue |
| out_b_oe | output | 1 | Port B output enable |
| out_a_upd | output | 1 | Port A refreshed this cycle |
| out_b_upd | output | 1 | Port B refreshed this cycle |
| out_dclk_en | output | 1 | Output data clock enable |
| out_hsync | output | 1 | Aligned, shaped sync output |

## Verification
Lines of odd and even length are run in each of the three modes, with and without port swap. Odd lines show whether alternation restarts at the line marker, and they leave unpaired pixels in parallel mode. Idle gaps are placed inside pairs, and markers are raised on idle cycles, to show that only valid beats advance the steering. Configuration inputs are changed on every cycle, so a design that latches them outside the marked beat gives different port contents. Sync widths of 0, 1 and several clocks are run at both polarities.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  parameter int unsigned PDM_CW  = 8;
  parameter int unsigned PDM_HSW = 8;
  localparam int unsigned NPORT  = 2;

  typedef logic [PDM_CW-1:0] chan_t;

  typedef struct packed {
    chan_t r;
    chan_t g;
    chan_t b;
  } pix_t;

  typedef struct packed {
    logic               dual;
    logic               par;
    logic               swap;
    logic               pol;
    logic [PDM_HSW-1:0] width;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{dual: 1'b0, par: 1'b0, swap: 1'b0,
                                 pol: 1'b1, width: {PDM_HSW{1'b0}}};
endpackage

// File: rtl/pdm_steer.sv
module pdm_steer
  import pdm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_hsync,
  input  pix_t               in_pix,
  input  logic               cfg_dual,
  input  logic               cfg_parallel,
  input  logic               cfg_swap,
  input  logic               cfg_sync_pol,
  input  logic [PDM_HSW-1:0] cfg_sync_width,
  output logic               s1_valid,
  output logic               s1_first,
  output logic               s1_slot,
  output pix_t               s1_pix,
  output cfg_t               s1_cfg
);
  cfg_t act_q;
  cfg_t cfg_new;
  cfg_t cfg_cur;
  logic next_q;
  logic slot;
  logic line_start;

  // configuration is captured only on the marked beat of a line
  always_comb begin
    cfg_new    = '{dual: cfg_dual, par: cfg_parallel, swap: cfg_swap,
                   pol: cfg_sync_pol, width: cfg_sync_width};
    line_start = in_valid & in_hsync;
    cfg_cur    = line_start ? cfg_new : act_q;
    slot       = line_start ? 1'b0 : next_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= CFG_RESET;
      next_q   <= 1'b0;
      s1_valid <= 1'b0;
      s1_first <= 1'b0;
      s1_slot  <= 1'b0;
      s1_pix   <= '0;
      s1_cfg   <= CFG_RESET;
    end else begin
      if (line_start) act_q <= cfg_new;
      if (in_valid)   next_q <= ~slot;
      s1_valid <= in_valid;
      s1_first <= line_start;
      s1_slot  <= slot;
      if (in_valid) s1_pix <= in_pix;
      s1_cfg   <= cfg_cur;
    end
  end
endmodule

// File: rtl/pdm_pack.sv
module pdm_pack
  import pdm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic s1_valid,
  input  logic s1_slot,
  input  pix_t s1_pix,
  input  logic dual,
  input  logic par,
  input  logic swap,
  output pix_t port_a,
  output pix_t port_b,
  output logic upd_a,
  output logic upd_b,
  output logic dclk_en,
  output logic b_oe
);
  logic [NPORT-1:0] wr;
  pix_t             wdata [NPORT];
  pix_t             port_q [NPORT];
  logic [NPORT-1:0] upd_q;
  pix_t             hold_q;
  logic             port_sel;

  always_comb begin
    wr       = '0;
    wdata[0] = s1_pix;
    wdata[1] = s1_pix;
    port_sel = s1_slot ^ swap;
    if (s1_valid) begin
      if (!dual) begin
        wr[0] = 1'b1;
      end else if (!par) begin
        wr[port_sel] = 1'b1;
      end else if (s1_slot) begin
        wr            = '1;
        wdata[swap]   = hold_q;
        wdata[!swap]  = s1_pix;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      dclk_en <= 1'b0;
      b_oe    <= 1'b0;
    end else begin
      if (s1_valid && dual && par && !s1_slot) hold_q <= s1_pix;
      dclk_en <= s1_valid & (~dual | s1_slot);
      b_oe    <= dual;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        port_q[p] <= '0;
        upd_q[p]  <= 1'b0;
      end else begin
        if (wr[p]) port_q[p] <= wdata[p];
        upd_q[p] <= wr[p];
      end
    end
  end

  assign port_a = port_q[0];
  assign port_b = port_q[1];
  assign upd_a  = upd_q[0];
  assign upd_b  = upd_q[1];
endmodule

// File: rtl/pdm_sync.sv
module pdm_sync
  import pdm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig,
  input  logic               pol,
  input  logic [PDM_HSW-1:0] width,
  output logic               hs_out
);
  logic [PDM_HSW-1:0] cnt_q;
  logic               pol_q;
  logic               busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pol_q <= 1'b1;
    end else begin
      pol_q <= pol;
      if (trig)             cnt_q <= width;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy   = (cnt_q != '0);
  assign hs_out = pol_q ? busy : ~busy;
endmodule

// File: rtl/pdm_pixel_demux.sv
module pdm_pixel_demux
  import pdm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_hsync,
  input  logic [PDM_CW-1:0]  in_r,
  input  logic [PDM_CW-1:0]  in_g,
  input  logic [PDM_CW-1:0]  in_b,
  input  logic               cfg_dual,
  input  logic               cfg_parallel,
  input  logic               cfg_swap,
  input  logic               cfg_sync_pol,
  input  logic [PDM_HSW-1:0] cfg_sync_width,
  output logic [PDM_CW-1:0]  out_a_r,
  output logic [PDM_CW-1:0]  out_a_g,
  output logic [PDM_CW-1:0]  out_a_b,
  output logic [PDM_CW-1:0]  out_b_r,
  output logic [PDM_CW-1:0]  out_b_g,
  output logic [PDM_CW-1:0]  out_b_b,
  output logic               out_b_oe,
  output logic               out_a_upd,
  output logic               out_b_upd,
  output logic               out_dclk_en,
  output logic               out_hsync
);
  pix_t in_pix;
  logic s1_valid;
  logic s1_first;
  logic s1_slot;
  pix_t s1_pix;
  cfg_t s1_cfg;
  pix_t port_a;
  pix_t port_b;
  logic b_oe;

  assign in_pix = '{r: in_r, g: in_g, b: in_b};

  pdm_steer u_steer (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_hsync       (in_hsync),
    .in_pix         (in_pix),
    .cfg_dual       (cfg_dual),
    .cfg_parallel   (cfg_parallel),
    .cfg_swap       (cfg_swap),
    .cfg_sync_pol   (cfg_sync_pol),
    .cfg_sync_width (cfg_sync_width),
    .s1_valid       (s1_valid),
    .s1_first       (s1_first),
    .s1_slot        (s1_slot),
    .s1_pix         (s1_pix),
    .s1_cfg         (s1_cfg)
  );

  pdm_pack u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .s1_valid (s1_valid),
    .s1_slot  (s1_slot),
    .s1_pix   (s1_pix),
    .dual     (s1_cfg.dual),
    .par      (s1_cfg.par),
    .swap     (s1_cfg.swap),
    .port_a   (port_a),
    .port_b   (port_b),
    .upd_a    (out_a_upd),
    .upd_b    (out_b_upd),
    .dclk_en  (out_dclk_en),
    .b_oe     (b_oe)
  );

  pdm_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig   (s1_valid & s1_first),
    .pol    (s1_cfg.pol),
    .width  (s1_cfg.width),
    .hs_out (out_hsync)
  );

  // port B reads zero while its output enable is low
  assign out_a_r  = port_a.r;
  assign out_a_g  = port_a.g;
  assign out_a_b  = port_a.b;
  assign out_b_r  = b_oe ? port_b.r : '0;
  assign out_b_g  = b_oe ? port_b.g : '0;
  assign out_b_b  = b_oe ? port_b.b : '0;
  assign out_b_oe = b_oe;
endmodule

// File: rtl/pdm_pixel_demux_chk.sv
module pdm_pixel_demux_chk
  import pdm_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_hsync,
  input logic               cfg_sync_pol,
  input logic [PDM_HSW-1:0] cfg_sync_width,
  input logic [PDM_CW-1:0]  out_b_r,
  input logic [PDM_CW-1:0]  out_b_g,
  input logic [PDM_CW-1:0]  out_b_b,
  input logic               out_b_oe,
  input logic               out_a_upd,
  input logic               out_b_upd,
  input logic               out_dclk_en,
  input logic               out_hsync
);
  logic [1:0] age_q;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end
  assign warm = (age_q == 2'd3);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !$past(in_valid, 2)) |-> !(out_a_upd || out_b_upd || out_dclk_en));

  // R12
  b_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_b_oe |-> (out_b_r == '0 && out_b_g == '0 && out_b_b == '0));

  // R12
  b_upd_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_b_upd |-> out_b_oe);

  // R4
  pair_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_a_upd && out_b_upd) |-> out_dclk_en);

  // R7
  oe_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_b_oe != $past(out_b_oe)) |-> $past(in_valid && in_hsync, 2));

  // R10
  sync_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(in_valid && in_hsync && cfg_sync_pol && cfg_sync_width != '0, 2))
      |-> out_hsync);
endmodule

bind pdm_pixel_demux pdm_pixel_demux_chk u_chk (.*);

// File: tb/pdm_pixel_demux_tb.sv
module pdm_pixel_demux_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_hsync = 1'b0;
  logic [7:0] in_r = '0, in_g = '0, in_b = '0;
  logic       cfg_dual = 1'b0, cfg_parallel = 1'b0, cfg_swap = 1'b0, cfg_sync_pol = 1'b1;
  logic [7:0] cfg_sync_width = '0;
  logic [7:0] out_a_r, out_a_g, out_a_b, out_b_r, out_b_g, out_b_b;
  logic       out_b_oe, out_a_upd, out_b_upd, out_dclk_en, out_hsync;

  always #4 clk = ~clk;

  pdm_pixel_demux u_dut (.*);

  typedef struct packed {
    logic [23:0] a;
    logic [23:0] b;
    logic au, bu, dk, oe, hs;
  } exp_t;

  int    n_chk = 0, n_err = 0;
  bit    done = 1'b0;
  string tag_ovr = "";

  // reference state
  logic        m_dual, m_par, m_swap, m_pol, m_next;
  logic [7:0]  m_cnt;
  logic [23:0] m_a, m_b, m_hold;
  exp_t        e_p0, e_p1, e_rst;
  string       t_p0, t_p1;

  task automatic model_reset();
    m_dual = 0; m_par = 0; m_swap = 0; m_pol = 1; m_next = 0;
    m_cnt = 0; m_a = 0; m_b = 0; m_hold = 0;
    e_rst = '{a: 24'd0, b: 24'd0, au: 0, bu: 0, dk: 0, oe: 0, hs: 0};
    e_p0 = e_rst; e_p1 = e_rst; t_p0 = "R1"; t_p1 = "R1";
  endtask

  task automatic model(input logic v, input logic hs, input logic [23:0] px,
                       input logic d, input logic p, input logic s, input logic pl,
                       input logic [7:0] w, output exp_t e, output string tg);
    logic slot, port;
    e.au = 0; e.bu = 0; e.dk = 0;
    if (v && hs) begin m_dual = d; m_par = p; m_swap = s; m_pol = pl; end
    if (v) begin
      slot = hs ? 1'b0 : m_next;
      m_next = ~slot;
      port = slot ^ m_swap;
      if (!m_dual) begin
        m_a = px; e.au = 1; e.dk = 1;
      end else if (!m_par) begin
        if (!port) begin m_a = px; e.au = 1; end
        else       begin m_b = px; e.bu = 1; end
        e.dk = slot;
      end else if (!slot) begin
        m_hold = px;
      end else begin
        if (m_swap) begin m_b = m_hold; m_a = px; end
        else        begin m_a = m_hold; m_b = px; end
        e.au = 1; e.bu = 1; e.dk = 1;
      end
    end
    if (v && hs) m_cnt = w;
    else if (m_cnt != 0) m_cnt = m_cnt - 8'd1;
    e.oe = m_dual;
    e.hs = m_pol ? (m_cnt != 0) : (m_cnt == 0);
    e.a  = m_a;
    e.b  = m_dual ? m_b : 24'd0;
    if (tag_ovr != "") tg = tag_ovr;
    else if (!m_dual)  tg = "R2";
    else if (!m_par)   tg = "R3";
    else               tg = "R4";
  endtask

  task automatic chk(input string req, input string what, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic compare(input exp_t e, input string tg);
    chk(tg, "port A data", {out_a_r, out_a_g, out_a_b}, e.a);
    chk(tg, "port B data", {out_b_r, out_b_g, out_b_b}, e.b);
    chk(tg, "update strobes", {out_a_upd, out_b_upd}, {e.au, e.bu});
    chk(tg, "data clock enable", out_dclk_en, e.dk);
    chk((tag_ovr != "") ? tag_ovr : "R12", "port B enable", out_b_oe, e.oe);
    chk((tag_ovr != "") ? tag_ovr : "R10", "sync output", out_hsync, e.hs);
  endtask

  // one pixel clock: check the result of the beat two cycles back, then drive
  task automatic cycle(input logic v, input logic hs, input logic [23:0] px,
                       input logic d, input logic p, input logic s, input logic pl,
                       input logic [7:0] w);
    exp_t  e;
    string tg;
    @(negedge clk);
    compare(e_p1, t_p1);
    in_valid = v; in_hsync = hs; {in_r, in_g, in_b} = px;
    cfg_dual = d; cfg_parallel = p; cfg_swap = s; cfg_sync_pol = pl; cfg_sync_width = w;
    model(v, hs, px, d, p, s, pl, w, e, tg);
    e_p1 = e_p0; t_p1 = t_p0;
    e_p0 = e;    t_p0 = tg;
  endtask

  task automatic line(input int len, input logic d, input logic p, input logic s,
                      input logic pl, input logic [7:0] w, input logic [7:0] base);
    for (int i = 0; i < len; i++)
      cycle(1'b1, i == 0, {base + 8'(i), 8'(i * 3), ~(base + 8'(i))}, d, p, s, pl, w);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++)
      cycle(1'b0, 1'b0, 24'hDEAD00 + 24'(i), 1'b0, 1'b0, 1'b0, 1'b1, 8'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int remain;
    logic rd, rp, rs, rpl, v, hs;
    logic [7:0] rw;
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    tag_ovr = "R1";
    compare(e_rst, "R1");
    rst_n = 1'b1;
    idle(2);

    // R9: single mode, marked pixel surfaces exactly two edges later with its sync
    tag_ovr = "R9";
    line(4, 1'b0, 1'b0, 1'b0, 1'b1, 8'd2, 8'h10);
    idle(3);

    // R5: odd lines in interleaved mode restart on the marker
    tag_ovr = "R5";
    line(3, 1'b1, 1'b0, 1'b0, 1'b1, 8'd1, 8'h20);
    line(5, 1'b1, 1'b0, 1'b0, 1'b1, 8'd1, 8'h30);
    line(1, 1'b1, 1'b0, 1'b0, 1'b1, 8'd1, 8'h38);
    line(4, 1'b1, 1'b1, 1'b0, 1'b1, 8'd1, 8'h3C);
    idle(2);

    // R6: swapped order, interleaved and parallel
    tag_ovr = "R6";
    line(5, 1'b1, 1'b0, 1'b1, 1'b1, 8'd3, 8'h40);
    line(6, 1'b1, 1'b1, 1'b1, 1'b1, 8'd3, 8'h50);
    idle(2);

    // R7: configuration wiggles mid-line, only the marked beat counts
    tag_ovr = "R7";
    cycle(1'b1, 1'b1, 24'h600001, 1'b1, 1'b1, 1'b0, 1'b1, 8'd2);
    cycle(1'b1, 1'b0, 24'h600002, 1'b0, 1'b0, 1'b1, 1'b0, 8'd9);
    cycle(1'b1, 1'b0, 24'h600003, 1'b0, 1'b1, 1'b1, 1'b0, 8'd7);
    cycle(1'b1, 1'b0, 24'h600004, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0);
    cycle(1'b0, 1'b0, 24'h600005, 1'b0, 1'b0, 1'b0, 1'b0, 8'd5);
    idle(3);

    // R8: idle gaps inside pairs and markers on idle cycles
    tag_ovr = "R8";
    cycle(1'b1, 1'b1, 24'h700001, 1'b1, 1'b0, 1'b0, 1'b1, 8'd1);
    cycle(1'b0, 1'b1, 24'h700002, 1'b0, 1'b1, 1'b1, 1'b0, 8'd6);
    cycle(1'b1, 1'b0, 24'h700003, 1'b1, 1'b0, 1'b0, 1'b1, 8'd1);
    cycle(1'b1, 1'b0, 24'h700004, 1'b1, 1'b0, 1'b0, 1'b1, 8'd1);
    cycle(1'b0, 1'b1, 24'h700005, 1'b0, 1'b0, 1'b0, 1'b0, 8'd4);
    cycle(1'b1, 1'b0, 24'h700006, 1'b1, 1'b0, 1'b0, 1'b1, 8'd1);
    idle(3);

    // R11: unpaired first pixel dropped at the next line
    tag_ovr = "R11";
    line(3, 1'b1, 1'b1, 1'b0, 1'b1, 8'd1, 8'h80);
    line(2, 1'b1, 1'b1, 1'b0, 1'b1, 8'd1, 8'h90);
    idle(3);

    // R10: widths 0, 1, 4 at both polarities
    tag_ovr = "R10";
    line(2, 1'b0, 1'b0, 1'b0, 1'b1, 8'd0, 8'hA0);
    idle(3);
    line(2, 1'b0, 1'b0, 1'b0, 1'b1, 8'd1, 8'hA4);
    idle(3);
    line(2, 1'b0, 1'b0, 1'b0, 1'b0, 8'd4, 8'hA8);
    idle(6);
    line(2, 1'b1, 1'b0, 1'b0, 1'b1, 8'd4, 8'hAC);
    idle(6);

    // R12: enable follows mode switches, port B zero while off
    tag_ovr = "R12";
    line(3, 1'b0, 1'b0, 1'b0, 1'b1, 8'd0, 8'hB0);
    line(3, 1'b1, 1'b1, 1'b0, 1'b1, 8'd0, 8'hB8);
    line(2, 1'b0, 1'b0, 1'b0, 1'b1, 8'd0, 8'hC0);
    idle(3);

    // random traffic; tags follow the active mode
    tag_ovr = "";
    remain = 0;
    for (int i = 0; i < 4000; i++) begin
      rd = 1'($urandom); rp = 1'($urandom); rs = 1'($urandom);
      rpl = 1'($urandom); rw = 8'($urandom % 6);
      if (remain == 0) begin
        v = 1'b1; hs = 1'b1; remain = 2 + int'($urandom % 12);
      end else begin
        v = ($urandom % 5) != 0;
        hs = !v && (($urandom % 8) == 0);
        if (v) remain--;
      end
      cycle(v, hs, 24'($urandom), rd, rp, rs, rpl, rw);
    end
    idle(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule